// File: doc/BRIEF.md
# Hybrid Stride/Context Load Value Predictor

This block guesses the data a speculatively executed load is about to return, so that a later thread need not stall or roll back when the producing thread has not yet written the location. Every table entry holds two guessers for one load address. The stride guesser keeps the last value and the last difference. The context guesser keeps the three most recent values and predicts by finding where the newest value repeated in that short history. Each guesser has its own 2-bit saturating confidence counter. A guess is offered only when the selected guesser is confident.

Training is deferred. The surrounding speculation logic reports each observed load outcome on the update port. These outcomes wait in a small buffer that belongs to the running epoch. A commit pulse drains the buffer into the tables, one entry per cycle and oldest first. A squash pulse throws the waiting outcomes away, so a thread that is rolled back never trains the tables. Load addresses are word addresses (the byte-offset bits are already dropped). The low 10 bits pick the entry, and the remaining bits form a tag that rejects lookups from other loads sharing that entry.

Top module: `hybrid_value_predictor`

## Requirements
- R1: After reset every entry is empty, so any lookup answers with rsp_en = 0 and rsp_value = 0.
- R2: A lookup with lk_req high gives rsp_valid high on the following cycle, together with that lookup's result. A cycle without lk_req gives rsp_valid low on the following cycle.
- R3: The stride guess is the stored last value plus the stored difference. An entry is allocated with difference 0, and each training step stores the new value and its difference from the previous one.
- R4: The context guess is taken from the history h0 (newest), h1, h2. If h1 equals h0, the guess is h0. Otherwise, if h2 equals h0, the guess is h1. Otherwise the guess is h2. A new entry fills all three with the first value.
- R5: Each confidence counter is 2 bits. It starts at 0 on allocation, rises by one when its guesser was right for the value being trained, falls by one when it was wrong, and saturates at 3 and at 0. A guesser is confident when its counter is 2 or more.
- R6: If exactly one guesser is confident, its guess is returned. If both are, the higher counter wins and a tie goes to stride. rsp_src is 0 for stride and 1 for context. If neither guesser is confident, rsp_en = 0, rsp_src = 0 and rsp_value = 0.
- R7: The entry index is lk_pc[9:0] and the tag is the remaining upper bits. A lookup whose tag differs from the stored tag gives no prediction.
- R8: Outcomes given on the update port have no effect on lookups until a commit pulse.
- R9: A squash pulse discards every buffered outcome that has not yet started draining. A later commit then leaves the tables unchanged.
- R10: The buffer holds DEPTH (default 4) outcomes. Outcomes that arrive while it is full are dropped.
- R11: After a commit, the buffered outcomes train the tables in arrival order, one per cycle, and all of them have been applied DEPTH cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | PC_W-2 | Word address of the load being looked up |
| rsp_valid | output | 1 | Lookup result present (one cycle after lk_req) |
| rsp_en | output | 1 | Prediction may be used |
| rsp_src | output | 1 | 0 = stride guesser, 1 = context guesser |
| rsp_value | output | DATA_W | Predicted load value (0 when rsp_en is low) |
| up_valid | input | 1 | Observed load outcome present |
| up_pc | input | PC_W-2 | Word address of the observed load |
| up_value | input | DATA_W | Value the load actually returned |
| commit | input | 1 | Epoch commits: apply buffered outcomes |
| squash | input | 1 | Epoch squashed: discard buffered outcomes |

## Verification
The hardest case to reach is the one where both guessers are confident for the same load, because the selection rule only matters then. Value streams that please one guesser usually defeat the other. The stimulus uses a constant stream to push both counters up together. It then continues that stream once more to test saturation, and then injects a single wrong value, which must leave both guessers confident at 2 with different guesses. Buffer overflow and squash are reached by pushing more outcomes than the buffer holds, or by squashing before a commit. Each case is followed by a lookup that shows whether the tables moved.

// File: rtl/hybrid_value_predictor.sv
module hybrid_value_predictor #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [PC_W-3:0]   lk_pc,
  output logic              rsp_valid,
  output logic              rsp_en,
  output logic              rsp_src,
  output logic [DATA_W-1:0] rsp_value,
  input  logic              up_valid,
  input  logic [PC_W-3:0]   up_pc,
  input  logic [DATA_W-1:0] up_value,
  input  logic              commit,
  input  logic              squash
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - 2 - IDX_W;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = PTR_W + 1;

  function automatic logic [DATA_W-1:0] ctx_guess(input logic [DATA_W-1:0] h0,
                                                  input logic [DATA_W-1:0] h1,
                                                  input logic [DATA_W-1:0] h2);
    if (h1 == h0)      return h0;
    else if (h2 == h0) return h1;
    else               return h2;
  endfunction

  function automatic logic [1:0] bump(input logic [1:0] c, input logic right);
    if (right) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  s_last [ENTRIES];
  logic [DATA_W-1:0]  s_step [ENTRIES];
  logic [1:0]         s_cf   [ENTRIES];
  logic [DATA_W-1:0]  c_h0   [ENTRIES];
  logic [DATA_W-1:0]  c_h1   [ENTRIES];
  logic [DATA_W-1:0]  c_h2   [ENTRIES];
  logic [1:0]         c_cf   [ENTRIES];

  // lookup side
  wire [IDX_W-1:0]  li     = lk_pc[IDX_W-1:0];
  wire [TAG_W-1:0]  lt     = lk_pc[PC_W-3:IDX_W];
  wire              l_hit  = vld[li] && (tag_q[li] == lt);
  wire [DATA_W-1:0] l_sp   = s_last[li] + s_step[li];
  wire [DATA_W-1:0] l_cp   = ctx_guess(c_h0[li], c_h1[li], c_h2[li]);
  wire              l_sok  = l_hit && s_cf[li][1];
  wire              l_cok  = l_hit && c_cf[li][1];
  wire              l_pick = l_cok && (!l_sok || (c_cf[li] > s_cf[li]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_en    <= 1'b0;
      rsp_src   <= 1'b0;
      rsp_value <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_en    <= lk_req && (l_sok || l_cok);
      rsp_src   <= lk_req && l_pick;
      rsp_value <= !lk_req ? '0 : l_pick ? l_cp : l_sok ? l_sp : '0;
    end
  end

  // per-epoch outcome buffer
  logic [PC_W-3:0]   f_pc  [DEPTH];
  logic [DATA_W-1:0] f_val [DEPTH];
  logic [PTR_W-1:0]  rd, wr;
  logic [CNT_W-1:0]  cnt, drain;

  wire              pop        = (drain != '0);
  wire              push       = up_valid && !squash && (cnt != CNT_W'(DEPTH));
  wire [CNT_W-1:0]  drain_rest = drain - CNT_W'(pop);
  wire [CNT_W-1:0]  cnt_next   = cnt + CNT_W'(push) - CNT_W'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd    <= '0;
      wr    <= '0;
      cnt   <= '0;
      drain <= '0;
    end else begin
      rd <= rd + PTR_W'(pop);
      if (squash) begin
        cnt   <= drain_rest;
        drain <= drain_rest;
        wr    <= rd + PTR_W'(pop) + drain_rest[PTR_W-1:0];
      end else begin
        cnt   <= cnt_next;
        wr    <= wr + PTR_W'(push);
        drain <= commit ? cnt_next : drain_rest;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_pc[wr]  <= up_pc;
      f_val[wr] <= up_value;
    end
  end

  // training side
  wire [PC_W-3:0]   h_pc  = f_pc[rd];
  wire [DATA_W-1:0] h_val = f_val[rd];
  wire [IDX_W-1:0]  hi    = h_pc[IDX_W-1:0];
  wire [TAG_W-1:0]  ht    = h_pc[PC_W-3:IDX_W];
  wire              t_hit = vld[hi] && (tag_q[hi] == ht);
  wire [DATA_W-1:0] t_sp  = s_last[hi] + s_step[hi];
  wire [DATA_W-1:0] t_cp  = ctx_guess(c_h0[hi], c_h1[hi], c_h2[hi]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (pop) vld[hi] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      if (!t_hit) begin
        tag_q[hi]  <= ht;
        s_last[hi] <= h_val;
        s_step[hi] <= '0;
        s_cf[hi]   <= 2'd0;
        c_h0[hi]   <= h_val;
        c_h1[hi]   <= h_val;
        c_h2[hi]   <= h_val;
        c_cf[hi]   <= 2'd0;
      end else begin
        s_cf[hi]   <= bump(s_cf[hi], t_sp == h_val);
        s_step[hi] <= h_val - s_last[hi];
        s_last[hi] <= h_val;
        c_cf[hi]   <= bump(c_cf[hi], t_cp == h_val);
        c_h2[hi]   <= c_h1[hi];
        c_h1[hi]   <= c_h0[hi];
        c_h0[hi]   <= h_val;
      end
    end
  end

  // R10
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CNT_W'(DEPTH)) && (drain <= cnt));

  // R9
  squash_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && !pop) |=> (cnt == '0));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  // R6
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_en |-> (rsp_value == '0 && !rsp_src));

  // R11
  commit_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !squash && !pop && cnt != '0) |=> pop);

endmodule

// File: tb/hybrid_value_predictor_tb.sv
`timescale 1ns/1ps
module hybrid_value_predictor_tb_top;
  localparam int PC_W = 32, DATA_W = 32, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 1'b0, up_valid = 1'b0, commit = 1'b0, squash = 1'b0;
  logic [PC_W-3:0] lk_pc = '0, up_pc = '0;
  logic [DATA_W-1:0] up_value = '0;
  logic rsp_valid, rsp_en, rsp_src;
  logic [DATA_W-1:0] rsp_value;

  int checks = 0, fails = 0;
  logic              q_en[$], q_src[$];
  logic [DATA_W-1:0] q_val[$];
  string             q_req[$];

  always #2.5 clk = ~clk;

  hybrid_value_predictor #(.PC_W(PC_W), .DATA_W(DATA_W), .IDX_W(10), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_en(rsp_en), .rsp_src(rsp_src), .rsp_value(rsp_value),
    .up_valid(up_valid), .up_pc(up_pc), .up_value(up_value),
    .commit(commit), .squash(squash));

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_en.size() == 0) begin
        fails++;
        $display("FAIL R2: response without request, actual valid=1 expected valid=0");
      end else begin
        logic e_en, e_src; logic [DATA_W-1:0] e_val; string e_req;
        e_en = q_en.pop_front(); e_src = q_src.pop_front();
        e_val = q_val.pop_front(); e_req = q_req.pop_front();
        if (rsp_en !== e_en || rsp_src !== e_src || rsp_value !== e_val) begin
          fails++;
          $display("FAIL %s: actual en=%0b src=%0b val=%0d expected en=%0b src=%0b val=%0d",
                   e_req, rsp_en, rsp_src, rsp_value, e_en, e_src, e_val);
        end
      end
    end
  end

  task automatic lookup(input logic [31:0] pc, input logic en, input logic src,
                        input logic [DATA_W-1:0] val, input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_pc = pc[31:2];
    q_en.push_back(en); q_src.push_back(src); q_val.push_back(val); q_req.push_back(req);
    @(posedge clk); #1 lk_req = 1'b0;
  endtask

  task automatic outcome(input logic [31:0] pc, input logic [DATA_W-1:0] v);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc[31:2]; up_value = v;
    @(posedge clk); #1 up_valid = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge clk); commit = 1'b1;
    @(posedge clk); #1 commit = 1'b0;
    repeat (DEPTH + 2) @(posedge clk);
  endtask

  task automatic pulse_squash();
    @(negedge clk); squash = 1'b1;
    @(posedge clk); #1 squash = 1'b0;
  endtask

  task automatic finish_up();
    repeat (3) @(posedge clk);
    checks++;
    if (q_en.size() != 0) begin
      fails++;
      $display("FAIL R2: missing responses, actual pending=%0d expected 0", q_en.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  localparam logic [31:0] PA = 32'h1004, PB = 32'h2008, PC = 32'h300C,
                          PD = 32'h0010, PALIAS = 32'h5004;

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 empty after reset
    lookup(PA, 1'b0, 1'b0, 0, "R1");
    lookup(PC, 1'b0, 1'b0, 0, "R1");
    // R8 outcomes invisible before commit
    outcome(PA, 10); outcome(PA, 20); outcome(PA, 30); outcome(PA, 40);
    lookup(PA, 1'b0, 1'b0, 0, "R8");
    // R3 R11 stride 10 -> guess 50, confidence 2
    pulse_commit();
    lookup(PA, 1'b1, 1'b0, 50, "R3");
    // R9 squash discards pending outcomes
    outcome(PA, 99); outcome(PA, 7);
    pulse_squash();
    pulse_commit();
    lookup(PA, 1'b1, 1'b0, 50, "R9");
    // R7 same index, different tag
    lookup(PALIAS, 1'b0, 1'b0, 0, "R7");
    // R4 alternating pattern: context confident, stride not
    outcome(PB, 7); outcome(PB, 9); outcome(PB, 7); outcome(PB, 9);
    pulse_commit();
    lookup(PB, 1'b1, 1'b1, 7, "R4");
    outcome(PB, 7);
    pulse_commit();
    lookup(PB, 1'b1, 1'b1, 9, "R4");
    // R6 constant stream: both at 3, tie goes to stride
    outcome(PC, 5); outcome(PC, 5); outcome(PC, 5); outcome(PC, 5);
    pulse_commit();
    lookup(PC, 1'b1, 1'b0, 5, "R6");
    // R5 saturation then one miss leaves both at 2; stride guess 7
    outcome(PC, 5);
    pulse_commit();
    outcome(PC, 6);
    pulse_commit();
    lookup(PC, 1'b1, 1'b0, 7, "R5");
    // R5 miss on stride from 2 drops below confidence
    outcome(PA, 55);
    pulse_commit();
    lookup(PA, 1'b0, 1'b0, 0, "R5");
    // R10 fifth outcome dropped: guess 10, not 12
    outcome(PD, 2); outcome(PD, 4); outcome(PD, 6); outcome(PD, 8); outcome(PD, 10);
    pulse_commit();
    lookup(PD, 1'b1, 1'b0, 10, "R10");
    // R2 idle cycles give no response (monitor flags any)
    repeat (4) @(posedge clk);
    lookup(PB, 1'b1, 1'b1, 9, "R2");
    finish_up();
  end
endmodule